// File: doc/BRIEF.md
# Performance Monitor Event-Branch Controller

This block sits beside a core's performance-monitor counters and turns a counter going negative into a branch that user code handles itself. It holds a monitor control register, a branch status register, a handler-address register and a return-address register, all written through one register write port and visible on output buses. When an enabled counter's top bit rises and the control register allows event branches, the block updates freeze and alert flags in the control register and posts a pending interrupt.

The pending interrupt is taken only while the core runs in user state. Taking it always clears the pending flag. If the status register's global-enable and monitor-enable bits are both set, the block issues a one-cycle redirect to the handler address. On the same edge it saves the current program counter as the return address and updates the status flags. If either enable bit is clear, the interrupt is dropped without a redirect.

Top module: `pm_evbranch`

## Requirements
- R1: After reset the control, status and return registers read zero, no interrupt is pending and no redirect is issued.
- R2: An alert is raised only in the cycle in which a counter's most significant bit goes from 0 to 1 while that counter's enable bit is set. A counter that stays negative, or whose enable bit is clear, raises nothing.
- R3: If control bit 4 (event-branch enable) is clear, an alert has no effect: no interrupt becomes pending and the control register is unchanged.
- R4: On an acted-on alert with control bit 3 (freeze-on-condition) set, bit 3 is cleared and bit 2 (freeze) is set. With bit 3 clear, bits 3 and 2 are left alone.
- R5: On an acted-on alert with control bit 1 (alert enable) set, bit 1 is cleared and bit 0 (alert occurred) is set. With bit 1 clear, bits 1 and 0 are left alone.
- R6: An acted-on alert makes `pend_o` read 1 from the next cycle.
- R7: A pending interrupt is taken only in a cycle with `user_i` high. Otherwise it stays pending.
- R8: Taking the interrupt clears it at the next edge. In that same cycle `redir_valid_o` is 1 with `redir_target_o` equal to the handler register, but only if status bits 2 (global enable) and 1 (monitor enable) are both set. Otherwise the interrupt is dropped with no redirect.
- R9: On the edge that ends a redirect cycle, status bit 2 is cleared, status bit 0 (monitor event occurred) is set, and the return register captures `pc_i`.
- R10: When a software write and a hardware flag update hit the same register in the same cycle, the hardware update wins on the bits it touches, and the written value is kept on all other bits.
- R11: `wr_sel_i` selects the target of a write: 0 control, 1 status, 2 handler, 3 return address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select for the write |
| wr_data_i | input | ADDR_W | Write data |
| ctr_val_i | input | NUM_CTR*CTR_W | Counter values, counter k in bits [k*CTR_W +: CTR_W] |
| ctr_en_i | input | NUM_CTR | Per-counter alert enable |
| pc_i | input | ADDR_W | Address of the next instruction |
| user_i | input | 1 | Core is in user state |
| redir_valid_o | output | 1 | One-cycle redirect request |
| redir_target_o | output | ADDR_W | Redirect target (handler register) |
| pend_o | output | 1 | Interrupt pending |
| ctl_o | output | 5 | Monitor control register |
| stat_o | output | 3 | Branch status register |
| ret_o | output | ADDR_W | Return-address register |

## Verification
The bench holds an interrupt pending while the core is privileged and then checks that it is delivered as soon as user state begins. A design that ignores the privilege flag would redirect too early, and one that loses the flag would never redirect. It checks that a counter that stays negative does not fire again, which catches level detection in place of edge detection. It checks that failed status gating drops the interrupt without a redirect or any register change, and that a software write colliding with an alert keeps the hardware's flag updates. A design with the wrong priority would lose the alert-occurred flag.

// File: rtl/pmeb_pkg.sv
package pmeb_pkg;
   localparam int CTL_W    = 5;
   localparam int CTL_SEEN = 0;
   localparam int CTL_AEN  = 1;
   localparam int CTL_FRZ  = 2;
   localparam int CTL_FOC  = 3;
   localparam int CTL_EVB  = 4;

   localparam int STAT_W   = 3;
   localparam int ST_SEEN  = 0;
   localparam int ST_MEN   = 1;
   localparam int ST_GLB   = 2;

   typedef enum logic [1:0] {
      SEL_CTL  = 2'd0,
      SEL_STAT = 2'd1,
      SEL_HND  = 2'd2,
      SEL_RET  = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/pmeb_neg_detect.sv
module pmeb_neg_detect #(
   parameter int NUM_CTR = 4,
   parameter int CTR_W   = 16
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic [NUM_CTR*CTR_W-1:0]   ctr_val_i,
   input  logic [NUM_CTR-1:0]         ctr_en_i,
   output logic                       alert_o
);
   localparam int MSB = CTR_W - 1;

   logic [NUM_CTR-1:0] msb_now, msb_q, hit;

   generate
      if (CTR_W < 2) begin : g_bad_width
         $error("CTR_W must be at least 2");
      end
      for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
         assign msb_now[g] = ctr_val_i[g*CTR_W + MSB];
         assign hit[g]     = ctr_en_i[g] & msb_now[g] & ~msb_q[g];
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (!rst_ni) msb_q <= '0;
      else         msb_q <= msb_now;
   end

   assign alert_o = |hit;
endmodule

// File: rtl/pmeb_ctl_reg.sv
module pmeb_ctl_reg
   import pmeb_pkg::*;
(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_i,
   input  logic [CTL_W-1:0]  wr_data_i,
   input  logic              alert_raw_i,
   output logic              alert_act_o,
   output logic [CTL_W-1:0]  ctl_q_o
);
   logic [CTL_W-1:0] ctl_q, ctl_d;

   assign alert_act_o = alert_raw_i & ctl_q[CTL_EVB];

   always_comb begin
      ctl_d = wr_i ? wr_data_i : ctl_q;
      if (alert_act_o) begin
         if (ctl_q[CTL_FOC]) begin
            ctl_d[CTL_FOC] = 1'b0;
            ctl_d[CTL_FRZ] = 1'b1;
         end
         if (ctl_q[CTL_AEN]) begin
            ctl_d[CTL_AEN]  = 1'b0;
            ctl_d[CTL_SEEN] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) ctl_q <= '0;
      else         ctl_q <= ctl_d;
   end

   assign ctl_q_o = ctl_q;
endmodule

// File: rtl/pmeb_branch_unit.sv
module pmeb_branch_unit
   import pmeb_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               wr_stat_i,
   input  logic               wr_hnd_i,
   input  logic               wr_ret_i,
   input  logic [ADDR_W-1:0]  wr_data_i,
   input  logic               alert_act_i,
   input  logic               user_i,
   input  logic [ADDR_W-1:0]  pc_i,
   output logic [STAT_W-1:0]  stat_o,
   output logic [ADDR_W-1:0]  hnd_o,
   output logic [ADDR_W-1:0]  ret_o,
   output logic               pend_o,
   output logic               fire_o
);
   logic [STAT_W-1:0] stat_q, stat_d;
   logic [ADDR_W-1:0] hnd_q, ret_q;
   logic              pend_q, take, gate_ok;

   assign take    = pend_q & user_i;
   assign gate_ok = stat_q[ST_GLB] & stat_q[ST_MEN];
   assign fire_o  = take & gate_ok;

   always_comb begin
      stat_d = wr_stat_i ? wr_data_i[STAT_W-1:0] : stat_q;
      if (fire_o) begin
         stat_d[ST_GLB]  = 1'b0;
         stat_d[ST_SEEN] = 1'b1;
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         stat_q <= '0;
         hnd_q  <= '0;
         ret_q  <= '0;
         pend_q <= 1'b0;
      end else begin
         stat_q <= stat_d;
         if (wr_hnd_i) hnd_q <= wr_data_i;
         if (fire_o)        ret_q <= pc_i;
         else if (wr_ret_i) ret_q <= wr_data_i;
         if (alert_act_i) pend_q <= 1'b1;
         else if (take)   pend_q <= 1'b0;
      end
   end

   assign stat_o = stat_q;
   assign hnd_o  = hnd_q;
   assign ret_o  = ret_q;
   assign pend_o = pend_q;
endmodule

// File: rtl/pm_evbranch.sv
module pm_evbranch
   import pmeb_pkg::*;
#(
   parameter int NUM_CTR = 4,
   parameter int CTR_W   = 16,
   parameter int ADDR_W  = 32
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic                      wr_en_i,
   input  logic [1:0]                wr_sel_i,
   input  logic [ADDR_W-1:0]         wr_data_i,
   input  logic [NUM_CTR*CTR_W-1:0]  ctr_val_i,
   input  logic [NUM_CTR-1:0]        ctr_en_i,
   input  logic [ADDR_W-1:0]         pc_i,
   input  logic                      user_i,
   output logic                      redir_valid_o,
   output logic [ADDR_W-1:0]         redir_target_o,
   output logic                      pend_o,
   output logic [CTL_W-1:0]          ctl_o,
   output logic [STAT_W-1:0]         stat_o,
   output logic [ADDR_W-1:0]         ret_o
);
   generate
      if (ADDR_W < CTL_W || ADDR_W < STAT_W) begin : g_bad_addr
         $error("ADDR_W too narrow for register writes");
      end
      if (NUM_CTR < 1) begin : g_bad_num
         $error("NUM_CTR must be at least 1");
      end
   endgenerate

   logic alert_raw, alert_act;
   logic wr_ctl, wr_stat, wr_hnd, wr_ret;

   assign wr_ctl  = wr_en_i & (wr_sel_i == SEL_CTL);
   assign wr_stat = wr_en_i & (wr_sel_i == SEL_STAT);
   assign wr_hnd  = wr_en_i & (wr_sel_i == SEL_HND);
   assign wr_ret  = wr_en_i & (wr_sel_i == SEL_RET);

   pmeb_neg_detect #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W)) u_detect (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ctr_val_i (ctr_val_i),
      .ctr_en_i  (ctr_en_i),
      .alert_o   (alert_raw)
   );

   pmeb_ctl_reg u_ctl (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_i        (wr_ctl),
      .wr_data_i   (wr_data_i[CTL_W-1:0]),
      .alert_raw_i (alert_raw),
      .alert_act_o (alert_act),
      .ctl_q_o     (ctl_o)
   );

   pmeb_branch_unit #(.ADDR_W(ADDR_W)) u_branch (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_stat_i   (wr_stat),
      .wr_hnd_i    (wr_hnd),
      .wr_ret_i    (wr_ret),
      .wr_data_i   (wr_data_i),
      .alert_act_i (alert_act),
      .user_i      (user_i),
      .pc_i        (pc_i),
      .stat_o      (stat_o),
      .hnd_o       (redir_target_o),
      .ret_o       (ret_o),
      .pend_o      (pend_o),
      .fire_o      (redir_valid_o)
   );
endmodule

// File: rtl/pm_evbranch_chk.sv
module pm_evbranch_chk
   import pmeb_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               user_i,
   input logic [ADDR_W-1:0]  pc_i,
   input logic               redir_valid_o,
   input logic               pend_o,
   input logic [CTL_W-1:0]   ctl_o,
   input logic [STAT_W-1:0]  stat_o,
   input logic [ADDR_W-1:0]  ret_o,
   input logic               alert_raw
);
   p_redir_user_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      redir_valid_o |-> user_i);

   p_redir_pend_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      redir_valid_o |-> (pend_o && stat_o[ST_GLB] && stat_o[ST_MEN]));

   p_ret_capture_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      redir_valid_o |=> (ret_o == $past(pc_i)));

   p_stat_update_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      redir_valid_o |=> (!stat_o[ST_GLB] && stat_o[ST_SEEN]));

   p_pend_source_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!pend_o && !(alert_raw && ctl_o[CTL_EVB])) |=> !pend_o);

   p_freeze_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (alert_raw && ctl_o[CTL_EVB] && ctl_o[CTL_FOC]) |=>
         (ctl_o[CTL_FRZ] && !ctl_o[CTL_FOC]));

   p_redir_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      redir_valid_o |=> !redir_valid_o);
endmodule

bind pm_evbranch pm_evbranch_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .user_i        (user_i),
   .pc_i          (pc_i),
   .redir_valid_o (redir_valid_o),
   .pend_o        (pend_o),
   .ctl_o         (ctl_o),
   .stat_o        (stat_o),
   .ret_o         (ret_o),
   .alert_raw     (alert_raw)
);

// File: tb/pm_evbranch_bench.sv
`timescale 1ns/1ps
module pm_evbranch_bench;
   import pmeb_pkg::*;
   localparam int NUM_CTR = 4;
   localparam int CTR_W   = 16;
   localparam int ADDR_W  = 32;

   logic                      clk = 1'b0;
   logic                      rst_ni = 1'b0;
   logic                      wr_en = 1'b0;
   logic [1:0]                wr_sel = 2'd0;
   logic [ADDR_W-1:0]         wr_data = '0;
   logic [NUM_CTR*CTR_W-1:0]  ctr_val = '0;
   logic [NUM_CTR-1:0]        ctr_en = 4'b1101;
   logic [ADDR_W-1:0]         pc = '0;
   logic                      user = 1'b0;
   logic                      redir_valid, pend;
   logic [ADDR_W-1:0]         redir_target, ret;
   logic [CTL_W-1:0]          ctl;
   logic [STAT_W-1:0]         stat;

   int n_tests = 0;
   int n_fail  = 0;

   always #2 clk = ~clk;

   pm_evbranch #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .ADDR_W(ADDR_W)) u_pm_evbranch (
      .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
      .wr_data_i(wr_data), .ctr_val_i(ctr_val), .ctr_en_i(ctr_en), .pc_i(pc),
      .user_i(user), .redir_valid_o(redir_valid), .redir_target_o(redir_target),
      .pend_o(pend), .ctl_o(ctl), .stat_o(stat), .ret_o(ret)
   );

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic wr_reg(reg_sel_e sel, logic [ADDR_W-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      #1;
   endtask

   task automatic set_ctr(int k, logic [CTR_W-1:0] v);
      ctr_val[k*CTR_W +: CTR_W] = v;
   endtask

   task automatic t_reset();
      chk("R1 ctl", ctl, 0);
      chk("R1 stat", stat, 0);
      chk("R1 ret", ret, 0);
      chk("R1 pend", pend, 0);
      chk("R1 redir", redir_valid, 0);
   endtask

   task automatic t_basic();
      wr_reg(SEL_HND, 32'h1000);
      wr_reg(SEL_STAT, 32'b110);
      wr_reg(SEL_CTL, 32'b11010);
      chk("R11 stat write", stat, 3'b110);
      chk("R11 ctl write", ctl, 5'b11010);
      @(negedge clk); set_ctr(0, 16'h8000);
      step();
      chk("R4 R5 ctl after alert", ctl, 5'b10101);
      chk("R6 pend", pend, 1);
      chk("R7 no redir in priv", redir_valid, 0);
      step();
      chk("R7 stays pending", pend, 1);
      pc = 32'h2040; user = 1'b1;
      #0.1;
      chk("R8 redir valid", redir_valid, 1);
      chk("R8 redir target", redir_target, 32'h1000);
      step();
      user = 1'b0;
      chk("R8 pend cleared", pend, 0);
      chk("R8 redir pulse", redir_valid, 0);
      chk("R9 stat", stat, 3'b011);
      chk("R9 ret", ret, 32'h2040);
      step();
      chk("R2 no refire while negative", pend, 0);
      set_ctr(0, 16'h0000);
      step();
      wr_reg(SEL_RET, 32'hABCD);
      chk("R11 ret write", ret, 32'hABCD);
   endtask

   task automatic t_disabled_ctr();
      wr_reg(SEL_CTL, 32'b10010);
      @(negedge clk); set_ctr(1, 16'hF000);
      step();
      chk("R2 disabled counter", pend, 0);
      chk("R2 ctl untouched", ctl, 5'b10010);
      set_ctr(1, 16'h0000);
      step();
   endtask

   task automatic t_no_evb();
      wr_reg(SEL_CTL, 32'b01010);
      @(negedge clk); set_ctr(0, 16'h8001);
      step();
      chk("R3 no pend", pend, 0);
      chk("R3 ctl unchanged", ctl, 5'b01010);
      set_ctr(0, 16'h0000);
      step();
   endtask

   task automatic t_gate_fail();
      wr_reg(SEL_CTL, 32'b10000);
      wr_reg(SEL_STAT, 32'b100);
      @(negedge clk); user = 1'b1; pc = 32'h3000; set_ctr(2, 16'h8000);
      step();
      chk("R6 pend", pend, 1);
      chk("R8 no redir when gated", redir_valid, 0);
      chk("R4 R5 flags idle", ctl, 5'b10000);
      step();
      user = 1'b0;
      chk("R8 dropped", pend, 0);
      chk("R8 stat unchanged", stat, 3'b100);
      chk("R8 ret unchanged", ret, 32'hABCD);
      set_ctr(2, 16'h0000);
      step();
   endtask

   task automatic t_collision();
      wr_reg(SEL_CTL, 32'b10010);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = SEL_CTL; wr_data = 32'b10110;
      set_ctr(3, 16'h8000);
      @(negedge clk);
      wr_en = 1'b0;
      #1;
      chk("R10 hw wins on flags", ctl, 5'b10101);
      chk("R6 pend", pend, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_ni = 1'b1;
      #1;
      t_reset();
      t_basic();
      t_disabled_ctr();
      t_no_evb();
      t_gate_fail();
      t_collision();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule